// File: doc/BRIEF.md
# Three-Input Bitwise Truth-Table Unit

This unit applies an arbitrary Boolean function of three inputs to three 512-bit vectors, bit by bit. An 8-bit truth-table immediate defines the function. At every bit position the bits taken from operands A, B and C form a 3-bit index, and that index picks one immediate bit as the output bit. Eight index values cover every combination of three bits, so any three-input bitwise function can be written as one immediate value.

The raw function vector then passes through a write mask. The mask applies to 32-bit or 64-bit elements. The function bits do not depend on the element size; only the mask grouping changes. A masked-off element is either forced to zero or keeps the value of operand A, which acts as the destination operand, as a zero/merge flag selects. With the mask enable low, every element takes the function result. The result is registered and appears one clock after its inputs are presented.

Top module: `tt3_bitfunc_unit`

## Requirements
- R1: `result` is a register. Inputs present at a rising clock edge appear on `result` after that edge. While `rst_n` is low, `result` is all zeros.
- R2: Output bit i equals `truthImm[{vecA[i], vecB[i], vecC[i]}]`, with A as the most significant index bit. Examples: 0x96 gives A^B^C, 0xE8 gives the majority of the three, 0xF0 copies A, 0xCC copies B, 0xAA copies C, 0x80 gives A&B&C, 0xFE gives A|B|C, and 0x00 and 0xFF give constants.
- R3: With `maskEn` = 0, every bit takes the function value, whatever the values of `wrMask`, `elemSel` and `zeroFill`.
- R4: With `elemSel` = 0 (32-bit elements) and `maskEn` = 1, `wrMask[k]` selects bits [32k+31:32k], for k = 0 to 15.
- R5: With `elemSel` = 1 (64-bit elements) and `maskEn` = 1, `wrMask[j]` selects bits [64j+63:64j], for j = 0 to 7. `wrMask[15:8]` is ignored.
- R6: An unselected element is all zeros when `zeroFill` = 1.
- R7: An unselected element equals the same bits of `vecA` when `zeroFill` = 0.
- R8: When every element is selected, the output bits are the same for both element sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vecA | input | 512 | Operand A: index MSB and merge source |
| vecB | input | 512 | Operand B: middle index bit |
| vecC | input | 512 | Operand C: index LSB |
| truthImm | input | 8 | Truth table for the bitwise function |
| elemSel | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| wrMask | input | 16 | Element write mask |
| maskEn | input | 1 | 1: apply wrMask, 0: write every element |
| zeroFill | input | 1 | 1: zero unselected elements, 0: keep vecA there |
| result | output | 512 | Registered result vector |

## Verification
The block holds only the result register, so a fault cannot persist beyond the next cycle. A wrong lane strobe, such as a 64-bit mask bit routed to the wrong 32-bit lane or a zero and a merge decision that are both active, corrupts exactly one 32-bit lane of `result` in the cycle after the input. A wrong index order in the lookup shows up as soon as an asymmetric immediate such as 0xF0 or 0xAA is applied. Checks therefore compare each result one cycle after its input, with masks that select sparse, alternating and upper-half patterns under both element sizes.

// File: rtl/tt3_pkg.sv
`timescale 1ns/1ps
package tt3_pkg;
  localparam int unsigned VEC_W      = 512;
  localparam int unsigned LANE_W     = 32;
  localparam int unsigned LANES      = VEC_W / LANE_W;
  localparam int unsigned WIDE_W     = 2 * LANE_W;
  localparam int unsigned WIDE_ELEMS = VEC_W / WIDE_W;
  localparam int unsigned IMM_W      = 8;

  typedef enum logic {ELEM_32 = 1'b0, ELEM_64 = 1'b1} elemSize_e;

  // Per-lane strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0] takeFunc;   // lane receives the truth-table result
    logic [LANES-1:0] clearLane;  // lane is forced to zero
  } laneStrobe_t;
endpackage

// File: rtl/tt3_lane_ctrl.sv
`timescale 1ns/1ps
module tt3_lane_ctrl
  import tt3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  elemSize_e         elemSize,
  input  logic [LANES-1:0]  mask,
  input  logic              maskEn,
  input  logic              zeroMode,
  output laneStrobe_t       strobes
);
  logic [LANES-1:0] takeVec;
  logic [LANES-1:0] clearVec;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic laneSel;
    // wide elements share one mask bit between two 32-bit lanes
    assign laneSel     = (elemSize == ELEM_64) ? mask[l/2] : mask[l];
    assign takeVec[l]  = !maskEn || laneSel;
    assign clearVec[l] = maskEn && !laneSel && zeroMode;
  end

  assign strobes = '{takeFunc: takeVec, clearLane: clearVec};

  // R3
  maskOffAllLanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !maskEn |-> (strobes.takeFunc == '1 && strobes.clearLane == '0));

  // R6
  strobeExclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.takeFunc & strobes.clearLane) == '0);

  // R7
  mergeNoClear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !zeroMode |-> strobes.clearLane == '0);
endmodule

// File: rtl/tt3_datapath.sv
`timescale 1ns/1ps
module tt3_datapath
  import tt3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VEC_W-1:0]  a,
  input  logic [VEC_W-1:0]  b,
  input  logic [VEC_W-1:0]  c,
  input  logic [IMM_W-1:0]  imm,
  input  laneStrobe_t       strobes,
  output logic [VEC_W-1:0]  result
);
  logic [VEC_W-1:0] funcVec;
  logic [VEC_W-1:0] nextVec;

  // per-bit 8-entry lookup
  always_comb begin
    for (int i = 0; i < VEC_W; i++) begin
      funcVec[i] = imm[{a[i], b[i], c[i]}];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_sel
    always_comb begin
      if (strobes.takeFunc[l])
        nextVec[l*LANE_W +: LANE_W] = funcVec[l*LANE_W +: LANE_W];
      else if (strobes.clearLane[l])
        nextVec[l*LANE_W +: LANE_W] = '0;
      else
        nextVec[l*LANE_W +: LANE_W] = a[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result <= '0;
    else        result <= nextVec;
  end

  // R1
  resetClear_chk: assert property (@(posedge clk)
    !rst_n |=> result == '0);

  // R2
  xorImm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(imm) == 8'h96 && $past(strobes.takeFunc) == '1)
    |-> result == $past(a ^ b ^ c));

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    // R6
    zeroLane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(strobes.clearLane[l]))
      |-> result[l*LANE_W +: LANE_W] == '0);
    // R7
    mergeLane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!strobes.takeFunc[l] && !strobes.clearLane[l]))
      |-> result[l*LANE_W +: LANE_W] == $past(a[l*LANE_W +: LANE_W]));
  end
endmodule

// File: rtl/tt3_bitfunc_unit.sv
`timescale 1ns/1ps
module tt3_bitfunc_unit
  import tt3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VEC_W-1:0]  vecA,
  input  logic [VEC_W-1:0]  vecB,
  input  logic [VEC_W-1:0]  vecC,
  input  logic [IMM_W-1:0]  truthImm,
  input  logic              elemSel,
  input  logic [LANES-1:0]  wrMask,
  input  logic              maskEn,
  input  logic              zeroFill,
  output logic [VEC_W-1:0]  result
);
  laneStrobe_t laneStrobes;

  tt3_lane_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .elemSize (elemSize_e'(elemSel)),
    .mask     (wrMask),
    .maskEn   (maskEn),
    .zeroMode (zeroFill),
    .strobes  (laneStrobes)
  );

  tt3_datapath i_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .a       (vecA),
    .b       (vecB),
    .c       (vecC),
    .imm     (truthImm),
    .strobes (laneStrobes),
    .result  (result)
  );
endmodule

// File: tb/test_tt3_bitfunc_unit.sv
`timescale 1ns/1ps
module test_tt3_bitfunc_unit;
  localparam int VW = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [VW-1:0] vecA = '0, vecB = '0, vecC = '0;
  logic [7:0]    truthImm = 8'h96;
  logic          elemSel = 1'b0;
  logic [15:0]   wrMask = '0;
  logic          maskEn = 1'b0;
  logic          zeroFill = 1'b0;
  logic [VW-1:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [VW-1:0] expQ[$];
  string         tagQ[$];

  always #4 clk = ~clk;

  tt3_bitfunc_unit i_tt3_bitfunc_unit (
    .clk(clk), .rst_n(rst_n), .vecA(vecA), .vecB(vecB), .vecC(vecC),
    .truthImm(truthImm), .elemSel(elemSel), .wrMask(wrMask),
    .maskEn(maskEn), .zeroFill(zeroFill), .result(result)
  );

  function automatic logic [VW-1:0] rvec();
    logic [VW-1:0] v;
    for (int k = 0; k < VW/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // reference from the requirements, bit by bit
  function automatic logic [VW-1:0] model(input logic [VW-1:0] a, b, c,
      input logic [7:0] imm, input logic wide, input logic [15:0] m,
      input logic en, input logic zf);
    logic [VW-1:0] r;
    logic [2:0] idx;
    int eBits;
    logic sel;
    eBits = wide ? 64 : 32;
    for (int i = 0; i < VW; i++) begin
      idx = {a[i], b[i], c[i]};
      sel = !en || m[i / eBits];
      r[i] = sel ? imm[idx] : (zf ? 1'b0 : a[i]);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [VW-1:0] a, b, c, input logic [7:0] imm,
      input logic wide, input logic [15:0] m, input logic en, input logic zf);
    @(negedge clk);
    vecA = a; vecB = b; vecC = c; truthImm = imm;
    elemSel = wide; wrMask = m; maskEn = en; zeroFill = zf;
  endtask

  task automatic sendExp(input logic [VW-1:0] a, b, c, input logic [7:0] imm,
      input logic wide, input logic [15:0] m, input logic en, input logic zf,
      input logic [VW-1:0] exp, input string tag);
    drive(a, b, c, imm, wide, m, en, zf);
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  task automatic send(input logic [VW-1:0] a, b, c, input logic [7:0] imm,
      input logic wide, input logic [15:0] m, input logic en, input logic zf,
      input string tag);
    sendExp(a, b, c, imm, wide, m, en, zf, model(a, b, c, imm, wide, m, en, zf), tag);
  endtask

  // monitor: one result per pushed item, one cycle after it was driven
  always @(posedge clk) begin
    #1;
    if (expQ.size() != 0) check(tagQ.pop_front(), result, expQ.pop_front());
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] a, b, c;
    // R1: reset clears the register even with live inputs
    vecA = rvec(); vecB = rvec(); vecC = rvec();
    repeat (3) @(negedge clk);
    check("R1 reset", result, '0);
    @(negedge clk);
    rst_n = 1'b1;

    a = rvec(); b = rvec(); c = rvec();
    // R2: closed-form functions, back to back (also R1 latency)
    sendExp(a, b, c, 8'h96, 1'b0, 16'h0, 1'b0, 1'b0, a ^ b ^ c, "R2 xor3");
    sendExp(a, b, c, 8'hE8, 1'b0, 16'h0, 1'b0, 1'b0, (a & b) | (a & c) | (b & c), "R2 majority");
    sendExp(a, b, c, 8'hF0, 1'b0, 16'h0, 1'b0, 1'b0, a, "R2 copyA");
    sendExp(a, b, c, 8'hCC, 1'b0, 16'h0, 1'b0, 1'b0, b, "R2 copyB");
    sendExp(a, b, c, 8'hAA, 1'b0, 16'h0, 1'b0, 1'b0, c, "R2 copyC");
    sendExp(a, b, c, 8'h80, 1'b0, 16'h0, 1'b0, 1'b0, a & b & c, "R2 and3");
    sendExp(a, b, c, 8'hFE, 1'b0, 16'h0, 1'b0, 1'b0, a | b | c, "R2 or3");
    sendExp(a, b, c, 8'h00, 1'b0, 16'h0, 1'b0, 1'b0, '0, "R2 const0");
    sendExp(a, b, c, 8'hFF, 1'b0, 16'h0, 1'b0, 1'b0, '1, "R2 const1");
    sendExp(a, b, c, 8'hC0, 1'b0, 16'h0, 1'b0, 1'b0, a & b, "R2 andAB");

    // R3: mask ignored when disabled, zeroFill set, both sizes
    sendExp(a, b, c, 8'h96, 1'b0, 16'h0000, 1'b0, 1'b1, a ^ b ^ c, "R3 en0 e32");
    sendExp(a, b, c, 8'h96, 1'b1, 16'h0000, 1'b0, 1'b1, a ^ b ^ c, "R3 en0 e64");

    // R4: 32-bit element masking
    send(a, b, c, 8'h5A, 1'b0, 16'hA5C3, 1'b1, 1'b0, "R4 e32 merge");
    send(a, b, c, 8'h5A, 1'b0, 16'hA5C3, 1'b1, 1'b1, "R4 e32 zero");
    send(a, b, c, 8'h3C, 1'b0, 16'h8001, 1'b1, 1'b1, "R4 e32 edge lanes");

    // R5: 64-bit element masking, upper mask half ignored
    sendExp(a, b, c, 8'hFF, 1'b1, 16'hFF00, 1'b1, 1'b1, '0, "R5 e64 upper ignored");
    send(a, b, c, 8'h69, 1'b1, 16'h005A, 1'b1, 1'b0, "R5 e64 merge");
    send(a, b, c, 8'h69, 1'b1, 16'hFF81, 1'b1, 1'b1, "R5 e64 zero");

    // R6 / R7: nothing selected
    sendExp(a, b, c, 8'hFF, 1'b0, 16'h0000, 1'b1, 1'b1, '0, "R6 all zeroed");
    sendExp(a, b, c, 8'hFF, 1'b0, 16'h0000, 1'b1, 1'b0, a, "R7 all merged");
    sendExp(a, b, c, 8'h00, 1'b1, 16'h0000, 1'b1, 1'b0, a, "R7 all merged e64");

    // R8: full masks give identical bits for both sizes
    sendExp(a, b, c, 8'hB2, 1'b0, 16'hFFFF, 1'b1, 1'b1,
            model(a, b, c, 8'hB2, 1'b0, 16'h0, 1'b0, 1'b0), "R8 e32 full");
    sendExp(a, b, c, 8'hB2, 1'b1, 16'h00FF, 1'b1, 1'b1,
            model(a, b, c, 8'hB2, 1'b0, 16'h0, 1'b0, 1'b0), "R8 e64 full");

    // mixed random traffic
    for (int n = 0; n < 24; n++) begin
      send(rvec(), rvec(), rvec(), 8'($urandom), 1'($urandom), 16'($urandom),
           1'($urandom), 1'($urandom), "R2 R4 R5 R6 R7 random");
    end

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule